// File: doc/BRIEF.md
# Vertical Blanking Pulse Generator

This block sits behind the vertical divider of a TV deflection controller. It follows the divider's half-line count, its reset strobe, its window mode and its field-rate flag. From these it builds the timing pulses one field needs:
- an anti-top-flutter pulse, which holds off the horizontal phase detector while the vertical sync is present;
- a vertical blanking pulse;
- a composite blanking output for the sandcastle stage;
- complementary charge and discharge windows for the vertical sawtooth;
- an inhibit for the sync slicing-level detector during the frame interval.

The sync separator supplies a one-clock strobe at the first equalizing pulse. The block uses this strobe only when the divider is locked, that is, in narrow-window or standard mode. In search mode the flutter pulse starts at the divider reset instead. A guard-fault input forces the composite output into blanking so that a failed deflection never shows as a burnt-in line.

Every output comes from a register and changes one clock after the input event that causes it. Count matches are equality compares, so a count that holds one value over several clocks does no harm.

Top module: `vblank_gen`

## Requirements
- R1: After rst_ni is released, all six outputs stay low until the first divider reset strobe. An equalizing strobe before that strobe is ignored.
- R2: When win_mode_i is 2'b00 (search) or 2'b11 (treated as search), atf_o rises one clock after vdiv_rst_i.
- R3: When win_mode_i is 2'b01 (narrow) or 2'b10 (standard), atf_o rises one clock after equ_start_i, and vdiv_rst_i does not start it. In search mode equ_start_i has no effect on atf_o.
- R4: atf_o falls one clock after vdiv_cnt_i equals 8 when field_60_i is 0 (50 Hz), or equals 10 when field_60_i is 1 (60 Hz).
- R5: vblank_o rises one clock after vdiv_rst_i. It falls one clock after vdiv_cnt_i equals 44 (50 Hz) or 34 (60 Hz).
- R6: comp_blank_o is high exactly when atf_o or vblank_o is high, or guard_fault_i was high one clock earlier.
- R7: saw_charge_o rises one clock after vdiv_rst_i and falls one clock after vdiv_cnt_i equals 26. After the first divider reset, saw_discharge_o is the complement of saw_charge_o.
- R8: slice_inh_o rises one clock after an honoured equalizing strobe and falls one clock after vdiv_rst_i. In search mode it never rises.
- R9: One clock after guard_fault_i is high, comp_blank_o is high, whatever the other pulses are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vdiv_cnt_i | input | CNT_W | Vertical divider half-line count |
| vdiv_rst_i | input | 1 | Divider reset strobe, count is 0 in that cycle |
| win_mode_i | input | 2 | Divider window mode: 00 search, 01 narrow, 10 standard, 11 as search |
| field_60_i | input | 1 | Field rate: 0 for 50 Hz, 1 for 60 Hz |
| equ_start_i | input | 1 | First equalizing pulse strobe |
| guard_fault_i | input | 1 | Deflection guard fault |
| atf_o | output | 1 | Anti-top-flutter pulse |
| vblank_o | output | 1 | Vertical blanking pulse |
| comp_blank_o | output | 1 | Composite blanking to the sandcastle stage |
| saw_charge_o | output | 1 | Sawtooth charge window |
| saw_discharge_o | output | 1 | Sawtooth discharge phase |
| slice_inh_o | output | 1 | Slicing-level detector inhibit |

## Verification
Some properties hold on every cycle, and the assertions check those:
- the composite output covers both pulses and any guard fault from the previous clock;
- the charge and discharge windows never overlap;
- a divider reset always opens the blanking and charge windows and closes the slicing inhibit;
- blanking and slicing inhibit rise only after their proper trigger.

Other properties depend on the exact end count at each field rate, or on which mode lets the equalizing strobe through. Only the bench scenarios show those:
- the flutter pulse that a locked divider leaves low when the strobe is missing;
- the strobes that are ignored before the first divider reset.

// File: rtl/vbg_pkg.sv
package vbg_pkg;
  typedef enum logic [1:0] {
    WIN_SEARCH   = 2'b00,
    WIN_NARROW   = 2'b01,
    WIN_STANDARD = 2'b10,
    WIN_RSVD     = 2'b11
  } win_mode_e;

  // locked divider modes take the equalizing strobe as flutter start
  function automatic logic equ_honoured(input win_mode_e m);
    return (m == WIN_NARROW) || (m == WIN_STANDARD);
  endfunction
endpackage

// File: rtl/vbg_end_match.sv
module vbg_end_match #(
  parameter int CNT_W  = 10,
  parameter int END_50 = 8,
  parameter int END_60 = 10
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             field_60_i,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] E50 = CNT_W'(END_50);
  localparam logic [CNT_W-1:0] E60 = CNT_W'(END_60);

  generate
    if (END_50 == END_60) begin : g_same
      assign hit_o = (cnt_i == E50);
    end else begin : g_rate
      assign hit_o = field_60_i ? (cnt_i == E60) : (cnt_i == E50);
    end
  endgenerate
endmodule

// File: rtl/vbg_pulse_reg.sv
module vbg_pulse_reg #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o,
  output logic next_o
);
  generate
    if (SET_WINS) begin : g_set_pri
      assign next_o = set_i | (q_o & ~clr_i);
    end else begin : g_clr_pri
      assign next_o = ~clr_i & (set_i | q_o);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= next_o;
  end
endmodule

// File: rtl/vbg_ramp_window.sv
module vbg_ramp_window #(
  parameter int CNT_W      = 10,
  parameter int CHARGE_LEN = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             vdiv_rst_i,
  input  logic             seen_next_i,
  output logic             charge_o,
  output logic             discharge_o
);
  logic hit, charge_next;

  vbg_end_match #(.CNT_W(CNT_W), .END_50(CHARGE_LEN), .END_60(CHARGE_LEN)) u_len (
    .cnt_i(cnt_i), .field_60_i(1'b0), .hit_o(hit)
  );

  vbg_pulse_reg #(.SET_WINS(1'b1)) u_charge (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(vdiv_rst_i), .clr_i(hit),
    .q_o(charge_o), .next_o(charge_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) discharge_o <= 1'b0;
    else         discharge_o <= seen_next_i & ~charge_next;
  end
endmodule

// File: rtl/vblank_gen.sv
module vblank_gen
  import vbg_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int ATF_END_50 = 8,
  parameter int ATF_END_60 = 10,
  parameter int BLK_END_50 = 44,
  parameter int BLK_END_60 = 34,
  parameter int CHARGE_LEN = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] vdiv_cnt_i,
  input  logic             vdiv_rst_i,
  input  logic [1:0]       win_mode_i,
  input  logic             field_60_i,
  input  logic             equ_start_i,
  input  logic             guard_fault_i,
  output logic             atf_o,
  output logic             vblank_o,
  output logic             comp_blank_o,
  output logic             saw_charge_o,
  output logic             saw_discharge_o,
  output logic             slice_inh_o
);
  win_mode_e mode;
  logic      locked, seen_q, seen_next, equ_ok;
  logic      atf_set, atf_hit, atf_next, blk_hit, vb_next;

  assign mode      = win_mode_e'(win_mode_i);
  assign locked    = equ_honoured(mode);
  assign seen_next = seen_q | vdiv_rst_i;
  assign equ_ok    = equ_start_i & seen_q & locked;
  assign atf_set   = equ_ok | (vdiv_rst_i & ~locked);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= seen_next;
  end

  vbg_end_match #(.CNT_W(CNT_W), .END_50(ATF_END_50), .END_60(ATF_END_60)) u_atf_end (
    .cnt_i(vdiv_cnt_i), .field_60_i(field_60_i), .hit_o(atf_hit)
  );

  vbg_end_match #(.CNT_W(CNT_W), .END_50(BLK_END_50), .END_60(BLK_END_60)) u_blk_end (
    .cnt_i(vdiv_cnt_i), .field_60_i(field_60_i), .hit_o(blk_hit)
  );

  vbg_pulse_reg #(.SET_WINS(1'b1)) u_atf (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(atf_set), .clr_i(atf_hit),
    .q_o(atf_o), .next_o(atf_next)
  );

  vbg_pulse_reg #(.SET_WINS(1'b1)) u_vblank (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(vdiv_rst_i), .clr_i(blk_hit),
    .q_o(vblank_o), .next_o(vb_next)
  );

  vbg_ramp_window #(.CNT_W(CNT_W), .CHARGE_LEN(CHARGE_LEN)) u_ramp (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(vdiv_cnt_i), .vdiv_rst_i(vdiv_rst_i),
    .seen_next_i(seen_next), .charge_o(saw_charge_o), .discharge_o(saw_discharge_o)
  );

  // divider reset closes the inhibit even when it coincides with a start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         slice_inh_o <= 1'b0;
    else if (vdiv_rst_i) slice_inh_o <= 1'b0;
    else if (equ_ok)     slice_inh_o <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) comp_blank_o <= 1'b0;
    else         comp_blank_o <= atf_next | vb_next | guard_fault_i;
  end
endmodule

// File: rtl/vblank_gen_chk.sv
module vblank_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       vdiv_rst_i,
  input logic [1:0] win_mode_i,
  input logic       equ_start_i,
  input logic       guard_fault_i,
  input logic       atf_o,
  input logic       vblank_o,
  input logic       comp_blank_o,
  input logic       saw_charge_o,
  input logic       saw_discharge_o,
  input logic       slice_inh_o
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  assert_comp_union_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (atf_o || vblank_o) |-> comp_blank_o);

  assert_guard_blank_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(guard_fault_i)) |-> comp_blank_o);

  assert_vblank_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $rose(vblank_o)) |-> $past(vdiv_rst_i));

  assert_rst_opens_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(vdiv_rst_i)) |-> (saw_charge_o && vblank_o && !saw_discharge_o));

  assert_charge_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(saw_charge_o && saw_discharge_o));

  assert_slice_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $rose(slice_inh_o)) |->
      ($past(equ_start_i) && ($past(win_mode_i) == 2'b01 || $past(win_mode_i) == 2'b10)));

  assert_slice_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(vdiv_rst_i)) |-> !slice_inh_o);

  assert_atf_search_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(vdiv_rst_i) && $past(win_mode_i) == 2'b00) |-> atf_o);
endmodule

bind vblank_gen vblank_gen_chk u_chk (.*);

// File: tb/tb_vblank_gen.sv
module tb_vblank_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] vdiv_cnt_i = '0;
  logic       vdiv_rst_i = 1'b0;
  logic [1:0] win_mode_i = 2'b00;
  logic       field_60_i = 1'b0;
  logic       equ_start_i = 1'b0;
  logic       guard_fault_i = 1'b0;
  logic       atf_o, vblank_o, comp_blank_o, saw_charge_o, saw_discharge_o, slice_inh_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  vblank_gen dut (.*);

  task automatic chk(input string tag, input string nm, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, nm, act, exp);
    end
  endtask

  task automatic tick(input int cnt, input logic rs, input logic eq);
    @(negedge clk_i);
    vdiv_cnt_i  = 10'(cnt);
    vdiv_rst_i  = rs;
    equ_start_i = eq;
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk_all_low(input string tag);
    chk(tag, "atf", atf_o, 1'b0);
    chk(tag, "vblank", vblank_o, 1'b0);
    chk(tag, "comp", comp_blank_o, 1'b0);
    chk(tag, "charge", saw_charge_o, 1'b0);
    chk(tag, "discharge", saw_discharge_o, 1'b0);
    chk(tag, "slice", slice_inh_o, 1'b0);
  endtask

  // R1: reset state and strobes ignored before the first divider reset
  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    chk_all_low("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    win_mode_i = 2'b01;
    tick(620, 1'b0, 1'b1);
    chk_all_low("R1");
    tick(5, 1'b0, 1'b0);
    chk_all_low("R1");
  endtask

  // one field: optional equalizing strobe, divider reset, count 1..60
  task automatic t_field(input logic [1:0] mode, input logic f60, input logic equ);
    logic hon, atf_on, a, v, c;
    int aend, bend;
    hon  = (mode == 2'b01) || (mode == 2'b10);
    aend = f60 ? 10 : 8;
    bend = f60 ? 34 : 44;
    win_mode_i = mode;
    field_60_i = f60;
    tick(700, 1'b0, 1'b0);
    if (equ) begin
      tick(620, 1'b0, 1'b1);
      chk("R3", "atf at strobe", atf_o, hon);
      chk("R8", "slice at strobe", slice_inh_o, hon);
      tick(621, 1'b0, 1'b0);
    end
    atf_on = hon ? equ : 1'b1;
    tick(0, 1'b1, 1'b0);
    chk(hon ? "R3" : "R2", "atf at reset", atf_o, atf_on);
    chk("R5", "vblank at reset", vblank_o, 1'b1);
    chk("R7", "charge at reset", saw_charge_o, 1'b1);
    chk("R7", "discharge at reset", saw_discharge_o, 1'b0);
    chk("R8", "slice at reset", slice_inh_o, 1'b0);
    chk("R6", "comp at reset", comp_blank_o, 1'b1);
    for (int k = 1; k <= 60; k++) begin
      tick(k, 1'b0, 1'b0);
      a = atf_on && (k < aend);
      v = (k < bend);
      c = (k < 26);
      chk("R4", "atf", atf_o, a);
      chk("R5", "vblank", vblank_o, v);
      chk("R7", "charge", saw_charge_o, c);
      chk("R7", "discharge", saw_discharge_o, !c);
      chk("R6", "comp", comp_blank_o, a | v);
      chk("R8", "slice", slice_inh_o, 1'b0);
    end
  endtask

  // R9: guard fault forces composite blanking outside the blanking window
  task automatic t_guard;
    @(negedge clk_i);
    guard_fault_i = 1'b1;
    tick(700, 1'b0, 1'b0);
    chk("R9", "comp under fault", comp_blank_o, 1'b1);
    chk("R9", "vblank under fault", vblank_o, 1'b0);
    @(negedge clk_i);
    guard_fault_i = 1'b0;
    tick(701, 1'b0, 1'b0);
    chk("R9", "comp after fault", comp_blank_o, 1'b0);
  endtask

  initial begin
    t_reset();
    t_field(2'b00, 1'b0, 1'b0);
    t_field(2'b00, 1'b1, 1'b1);
    t_field(2'b11, 1'b0, 1'b0);
    t_field(2'b01, 1'b0, 1'b1);
    t_field(2'b10, 1'b1, 1'b1);
    t_field(2'b01, 1'b1, 1'b0);
    t_guard();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule